// File: doc/BRIEF.md
# Camera Register Controller with Atomic Multi-Byte Access

This controller owns the byte-addressed control register space of a camera core. The space is shared by two masters. One is a camera-control serial slave, which talks to the controller through single-cycle strobes: index-high, index-low, push, pop and stop. The other is a simple local bus used by the camera core itself. The space is stored in two banks, and the top index bit selects between them. The full-size configuration covers indices 0x0000 to 0x3FFF. The default parameter set builds a 1 KB space so that elaboration stays small.

The serial side works through a 16-bit index that it loads one byte at a time. The index moves up by one after every push and every pop. An input table marks the indices at which 16-bit and 32-bit registers begin.

A multi-byte write collects its bytes in a holding buffer and reaches memory in a single cycle once the last byte arrives. A multi-byte read captures the whole register when its first byte is fetched. The local bus has priority: while it is active, the serial-side ready flag is low, so the slave stretches the clock. A command register at index 0x0010 produces one-cycle start and stop pulses.

Top module: `camreg_ctrl`

## Requirements
- R1: After reset `slv_rdy` is 1, `lb_rdy`, `start_pulse` and `stop_pulse` are 0, `tx_byte` is 0x00 and every register byte reads 0x00.
- R2: `idx_hi_stb` loads `rx_byte` into index bits 15:8 and `idx_lo_stb` loads it into bits 7:0. Each pop places the byte at the current index on `tx_byte` in the cycle after the strobe. The index increments by one after every push and every pop. `tx_byte` changes only on a pop.
- R3: A push to a valid index that does not start a wide register writes `rx_byte` to that byte at once.
- R4: `wide_map` holds NENT 16-bit entries, with entry e at bits [16e+15:16e]. Bits 13:0 of an entry are the base index. Bits 15:14 are the size code: 00 means unused, 01 means 2 bytes, 10 or 11 means 4 bytes. A push run that starts at a base index leaves memory unchanged until its last byte. All of its bytes are then written in one cycle, with the first byte received at the base (lowest) address, so the most significant byte sits first.
- R5: A pop at a wide-register base captures all of its bytes. The following pops of that register return the captured bytes, even if the memory is changed in between.
- R6: In the cycle after `lb_sel` is seen high, `slv_rdy` is 0. It stays 0 until the local access has completed and `lb_sel` has been released.
- R7: An index is valid when it is below 2^IDX_AW. A push at an invalid index is consumed and increments the index, but it writes nothing, including nothing at the aliased low address. A pop at an invalid index returns 0x00.
- R8: Writing 0x02 to index 0x0010, from either side, raises `start_pulse` for exactly one cycle after the write. Writing 0x01 raises `stop_pulse` in the same way. Any other value raises neither.
- R9: A local read spends exactly two wait cycles with `lb_rdy` low, then presents `lb_rdata` while `lb_rdy` is high for one cycle. A local write raises `lb_rdy` in the cycle after it is accepted.
- R10: A stop strobe discards a partially received wide-register write, so none of its bytes reach memory. Loading the index also clears pending partial state.
- R11: The two banks hold independent bytes. Indices that differ only in the top index bit keep different values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_hi_stb | input | 1 | Load index high byte from rx_byte |
| idx_lo_stb | input | 1 | Load index low byte from rx_byte |
| push_stb | input | 1 | Write rx_byte at the index |
| pop_stb | input | 1 | Fetch the byte at the index |
| stop_stb | input | 1 | Serial transfer ended |
| rx_byte | input | 8 | Byte received from the serial slave |
| tx_byte | output | 8 | Byte returned by the last pop |
| slv_rdy | output | 1 | Serial side may strobe; low requests clock stretch |
| lb_sel | input | 1 | Local-bus request, held until lb_rdy |
| lb_write | input | 1 | Local-bus direction, 1 = write |
| lb_addr | input | IDX_AW | Local-bus byte address |
| lb_wdata | input | 8 | Local-bus write byte |
| lb_rdata | output | 8 | Local-bus read byte |
| lb_rdy | output | 1 | Local access complete |
| wide_map | input | NENT*16 | Table of wide-register bases and sizes |
| start_pulse | output | 1 | One-cycle start command |
| stop_pulse | output | 1 | One-cycle stop command |

## Verification
The bench writes the first bytes of a four-byte register and reads that register over the local bus before the last byte arrives. A design that commits each byte as it comes would show new data there. It then changes a byte of a register between pops, which exposes a design that reads memory on every pop instead of using the captured copy. It pushes at invalid indices just past the top of the space and checks the low addresses those indices alias to, catching a design that drops the upper index bits. It also ends a partial wide write with a stop and then writes the same register again, which fails if stale bytes are committed or if the buffer count survives the stop. Wait-cycle counts on local reads and the ready and pulse timing around the command register pin down each registered stage.

// File: rtl/camreg_pkg.sv
package camreg_pkg;
    localparam int LANES  = 4;
    localparam int ENT_W  = 16;
    localparam int BASE_W = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_DONE = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/camreg_sizer.sv
module camreg_sizer
    import camreg_pkg::*;
#(
    parameter int NENT = 4
) (
    input  logic [15:0]           idx,
    input  logic [NENT*ENT_W-1:0] tbl,
    output logic [2:0]            nbytes
);
    always_comb begin
        nbytes = 3'd1;
        for (int e = 0; e < NENT; e++) begin
            if (tbl[e*ENT_W+BASE_W +: 2] != 2'b00 &&
                {2'b00, tbl[e*ENT_W +: BASE_W]} == idx) begin
                nbytes = (tbl[e*ENT_W+BASE_W +: 2] == 2'b01) ? 3'd2 : 3'd4;
            end
        end
    end
endmodule

// File: rtl/camreg_bank.sv
module camreg_bank
    import camreg_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [2:0]           wn,
    input  logic [LANES*8-1:0]   wdata,
    input  logic [AW-1:0]        raddr,
    output logic [LANES*8-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            for (int k = 0; k < LANES; k++) begin
                if (3'(k) < wn) mem[waddr + AW'(k)] <= wdata[k*8 +: 8];
            end
        end
    end

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign rdata[k*8 +: 8] = mem[raddr + AW'(k)];
        end
    endgenerate
endmodule

// File: rtl/camreg_ctrl.sv
module camreg_ctrl
    import camreg_pkg::*;
#(
    parameter int IDX_AW = 10,
    parameter int NENT   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_hi_stb,
    input  logic                   idx_lo_stb,
    input  logic                   push_stb,
    input  logic                   pop_stb,
    input  logic                   stop_stb,
    input  logic [7:0]             rx_byte,
    output logic [7:0]             tx_byte,
    output logic                   slv_rdy,
    input  logic                   lb_sel,
    input  logic                   lb_write,
    input  logic [IDX_AW-1:0]      lb_addr,
    input  logic [7:0]             lb_wdata,
    output logic [7:0]             lb_rdata,
    output logic                   lb_rdy,
    input  logic [NENT*ENT_W-1:0]  wide_map,
    output logic                   start_pulse,
    output logic                   stop_pulse
);
    localparam int BANK_AW = IDX_AW - 1;
    localparam int NBANK   = 2;
    localparam int LW      = $clog2(LANES);
    localparam logic [IDX_AW-1:0] CMD_IDX = IDX_AW'(16);
    localparam logic [7:0] CMD_GO   = 8'h02;
    localparam logic [7:0] CMD_HALT = 8'h01;

    typedef struct packed {
        ctl_state_e               st;
        logic [15:0]              idx;
        logic [LANES-1:0][7:0]    wbuf;
        logic [IDX_AW-1:0]        wbase;
        logic [2:0]               wneed;
        logic [2:0]               wcnt;
        logic [LANES-1:0][7:0]    rbuf;
        logic [2:0]               rpos;
        logic [2:0]               rleft;
        logic [7:0]               tx;
        logic                     rdy;
        logic [IDX_AW-1:0]        lbaddr;
        logic [7:0]               lbdata;
        logic                     startp;
        logic                     stopp;
    } ctl_s;

    ctl_s q, d;

    logic [2:0]                       sz_idx;
    logic                             idx_ok;
    logic [IDX_AW-1:0]                raddr;
    logic [NBANK-1:0][LANES*8-1:0]    bank_rd;
    logic [LANES*8-1:0]               rd_word;
    logic                             we;
    logic [IDX_AW-1:0]                waddr;
    logic [2:0]                       wn;
    logic [LANES*8-1:0]               wdata;
    logic                             i2c_any;

    camreg_sizer #(.NENT(NENT)) u_size (
        .idx    (q.idx),
        .tbl    (wide_map),
        .nbytes (sz_idx)
    );

    assign idx_ok  = (q.idx >> IDX_AW) == 16'd0;
    assign raddr   = (q.st == ST_IDLE) ? q.idx[IDX_AW-1:0] : q.lbaddr;
    assign i2c_any = idx_hi_stb | idx_lo_stb | push_stb | pop_stb | stop_stb;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic bank_we;
            assign bank_we = we && (waddr[IDX_AW-1] == 1'(b));
            camreg_bank #(.AW(BANK_AW)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (bank_we),
                .waddr (waddr[BANK_AW-1:0]),
                .wn    (wn),
                .wdata (wdata),
                .raddr (raddr[BANK_AW-1:0]),
                .rdata (bank_rd[b])
            );
        end
    endgenerate

    assign rd_word = bank_rd[raddr[IDX_AW-1]];

    always_comb begin
        d        = q;
        we       = 1'b0;
        waddr    = q.idx[IDX_AW-1:0];
        wn       = 3'd1;
        wdata    = '0;
        d.startp = 1'b0;
        d.stopp  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (i2c_any) begin
                    if (idx_hi_stb) begin
                        d.idx[15:8] = rx_byte;
                        d.wcnt      = 3'd0;
                        d.rleft     = 3'd0;
                    end else if (idx_lo_stb) begin
                        d.idx[7:0]  = rx_byte;
                        d.wcnt      = 3'd0;
                        d.rleft     = 3'd0;
                    end else if (stop_stb) begin
                        d.wcnt      = 3'd0;
                        d.rleft     = 3'd0;
                    end else if (push_stb) begin
                        d.idx = q.idx + 16'd1;
                        if (q.wcnt != 3'd0) begin
                            d.wbuf[q.wcnt[LW-1:0]] = rx_byte;
                            if (q.wcnt + 3'd1 == q.wneed) begin
                                we     = 1'b1;
                                waddr  = q.wbase;
                                wn     = q.wneed;
                                wdata  = d.wbuf;
                                d.wcnt = 3'd0;
                            end else begin
                                d.wcnt = q.wcnt + 3'd1;
                            end
                        end else if (idx_ok) begin
                            if (sz_idx == 3'd1) begin
                                we         = 1'b1;
                                wdata[7:0] = rx_byte;
                            end else begin
                                d.wbuf    = '0;
                                d.wbuf[0] = rx_byte;
                                d.wbase   = q.idx[IDX_AW-1:0];
                                d.wneed   = sz_idx;
                                d.wcnt    = 3'd1;
                            end
                        end
                    end else begin
                        d.idx = q.idx + 16'd1;
                        if (q.rleft != 3'd0) begin
                            d.tx    = q.rbuf[q.rpos[LW-1:0]];
                            d.rpos  = q.rpos + 3'd1;
                            d.rleft = q.rleft - 3'd1;
                        end else if (idx_ok) begin
                            d.rbuf  = rd_word;
                            d.tx    = rd_word[7:0];
                            d.rpos  = 3'd1;
                            d.rleft = sz_idx - 3'd1;
                        end else begin
                            d.tx = 8'h00;
                        end
                    end
                end else if (lb_sel) begin
                    d.lbaddr = lb_addr;
                    if (lb_write) begin
                        we         = 1'b1;
                        waddr      = lb_addr;
                        wdata[7:0] = lb_wdata;
                        d.st       = ST_DONE;
                    end else begin
                        d.st = ST_RD1;
                    end
                end
            end
            ST_RD1: d.st = ST_RD2;
            ST_RD2: begin
                d.lbdata = rd_word[7:0];
                d.st     = ST_DONE;
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase

        if (we && wn == 3'd1 && waddr == CMD_IDX) begin
            d.startp = (wdata[7:0] == CMD_GO);
            d.stopp  = (wdata[7:0] == CMD_HALT);
        end

        d.rdy = (d.st == ST_IDLE) && !lb_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.rdy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tx_byte     = q.tx;
    assign slv_rdy     = q.rdy;
    assign lb_rdata    = q.lbdata;
    assign lb_rdy      = (q.st == ST_DONE);
    assign start_pulse = q.startp;
    assign stop_pulse  = q.stopp;
endmodule

// File: rtl/camreg_ctrl_chk.sv
module camreg_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lb_sel,
    input logic       lb_rdy,
    input logic       slv_rdy,
    input logic       pop_stb,
    input logic [7:0] tx_byte,
    input logic       start_pulse,
    input logic       stop_pulse
);
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R8

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R8

    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse); // R8

    AST_LOCAL_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        lb_sel |=> !slv_rdy); // R6

    AST_RDY_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rdy |-> !slv_rdy); // R6

    AST_LB_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lb_rdy |=> !lb_rdy); // R9

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_stb |=> $stable(tx_byte)); // R2
endmodule

bind camreg_ctrl camreg_ctrl_chk u_chk (.*);

// File: tb/sim_camreg_ctrl.sv
`timescale 1ns/1ps
module sim_camreg_ctrl;
    localparam int IDX_AW = 10;
    localparam int NENT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic idx_hi_stb = 0, idx_lo_stb = 0, push_stb = 0, pop_stb = 0, stop_stb = 0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] tx_byte;
    logic slv_rdy;
    logic lb_sel = 0, lb_write = 0;
    logic [IDX_AW-1:0] lb_addr = '0;
    logic [7:0] lb_wdata = 8'h00;
    logic [7:0] lb_rdata;
    logic lb_rdy;
    logic [NENT*16-1:0] wide_map;
    logic start_pulse, stop_pulse;

    int n_chk = 0;
    int n_fail = 0;

    // entry0: 2 bytes at 0x020, entry1: 4 bytes at 0x030, entry2: 4 bytes at 0x230
    assign wide_map = {16'h0000, {2'b10, 14'h0230}, {2'b10, 14'h0030}, {2'b01, 14'h0020}};

    always #2 clk = ~clk;

    camreg_ctrl #(.IDX_AW(IDX_AW), .NENT(NENT)) u0 (.*);

    // {index[15:0], byte[7:0]}: serial push, then local read back
    localparam logic [23:0] VEC [6] = '{
        24'h0005_11, 24'h0205_22, 24'h0100_33,
        24'h03FF_44, 24'h0006_55, 24'h02FF_5A
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_rdy();
        while (slv_rdy !== 1'b1) @(negedge clk);
    endtask

    task automatic strobe(input int kind, input logic [7:0] b);
        wait_rdy();
        rx_byte = b;
        case (kind)
            0: idx_hi_stb = 1'b1;
            1: idx_lo_stb = 1'b1;
            2: push_stb   = 1'b1;
            3: pop_stb    = 1'b1;
            default: stop_stb = 1'b1;
        endcase
        @(negedge clk);
        {idx_hi_stb, idx_lo_stb, push_stb, pop_stb, stop_stb} = '0;
    endtask

    task automatic set_idx(input logic [15:0] a);
        strobe(0, a[15:8]);
        strobe(1, a[7:0]);
    endtask

    task automatic push(input logic [7:0] b);
        strobe(2, b);
    endtask

    task automatic pop(output logic [7:0] b);
        strobe(3, 8'h00);
        b = tx_byte;
    endtask

    task automatic lb_wr(input logic [IDX_AW-1:0] a, input logic [7:0] v, output int waits);
        lb_sel = 1'b1; lb_write = 1'b1; lb_addr = a; lb_wdata = v;
        waits = 0;
        @(negedge clk);
        while (!lb_rdy && waits < 20) begin waits++; @(negedge clk); end
        lb_sel = 1'b0; lb_write = 1'b0;
    endtask

    task automatic lb_rd(input logic [IDX_AW-1:0] a, output logic [7:0] v, output int waits);
        lb_sel = 1'b1; lb_write = 1'b0; lb_addr = a;
        waits = 0;
        @(negedge clk);
        while (!lb_rdy && waits < 20) begin waits++; @(negedge clk); end
        v = lb_rdata;
        lb_sel = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 slv_rdy", slv_rdy, 1);
        chk("R1 lb_rdy", lb_rdy, 0);
        chk("R1 pulses", {start_pulse, stop_pulse}, 0);
        chk("R1 tx_byte", tx_byte, 0);
        lb_rd(10'h000, v, w);
        chk("R1 mem zero", v, 8'h00);

        // R3 / R11: vector table
        for (int i = 0; i < 6; i++) begin
            set_idx(VEC[i][23:8]);
            push(VEC[i][7:0]);
            lb_rd(VEC[i][17:8], v, w);
            chk("R3 push then local read", v, VEC[i][7:0]);
            chk("R9 read waits", w, 2);
        end
        lb_rd(10'h005, v, w);
        chk("R11 low bank kept", v, 8'h11);
        lb_rd(10'h205, v, w);
        chk("R11 high bank kept", v, 8'h22);

        // R2 sequential push and pop with auto-increment
        set_idx(16'h0005);
        push(8'hA1);
        push(8'hA2);
        set_idx(16'h0005);
        pop(v); chk("R2 pop idx5", v, 8'hA1);
        pop(v); chk("R2 pop idx6", v, 8'hA2);
        pop(v); chk("R2 pop idx7", v, 8'h00);

        // R4 atomic 32-bit write, MSB at base
        set_idx(16'h0030);
        push(8'hDE); push(8'hAD); push(8'hBE);
        lb_rd(10'h030, v, w);
        chk("R4 no partial commit", v, 8'h00);
        push(8'hEF);
        lb_rd(10'h030, v, w); chk("R4 byte0", v, 8'hDE);
        lb_rd(10'h033, v, w); chk("R4 byte3", v, 8'hEF);
        set_idx(16'h0020);
        push(8'h12);
        lb_rd(10'h020, v, w); chk("R4 16b pending", v, 8'h00);
        push(8'h34);
        lb_rd(10'h021, v, w); chk("R4 16b low byte", v, 8'h34);

        // R5 read snapshot
        set_idx(16'h0030);
        pop(v); chk("R5 first byte", v, 8'hDE);
        lb_wr(10'h031, 8'h77, w);
        chk("R9 write ready next cycle", w, 0);
        pop(v); chk("R5 snapshot byte1", v, 8'hAD);
        pop(v); chk("R5 snapshot byte2", v, 8'hBE);
        pop(v); chk("R5 snapshot byte3", v, 8'hEF);
        set_idx(16'h0031);
        pop(v); chk("R5 fresh after snapshot", v, 8'h77);

        // R7 invalid index
        set_idx(16'h0500);
        push(8'h99);
        lb_rd(10'h100, v, w);
        chk("R7 no alias write", v, 8'h33);
        pop(v); chk("R7 invalid pop", v, 8'h00);
        set_idx(16'h03FF);
        push(8'h66);
        push(8'h77);
        lb_rd(10'h3FF, v, w); chk("R7 last valid", v, 8'h66);
        lb_rd(10'h000, v, w); chk("R7 past end not written", v, 8'h00);

        // R10 stop discards partial buffer
        set_idx(16'h0230);
        push(8'h01); push(8'h02);
        strobe(4, 8'h00);
        lb_rd(10'h230, v, w); chk("R10 discarded b0", v, 8'h00);
        lb_rd(10'h231, v, w); chk("R10 discarded b1", v, 8'h00);
        set_idx(16'h0230);
        push(8'h0A); push(8'h0B); push(8'h0C); push(8'h0D);
        lb_rd(10'h230, v, w); chk("R10 fresh b0", v, 8'h0A);
        lb_rd(10'h233, v, w); chk("R10 fresh b3", v, 8'h0D);

        // R8 start pulse through serial push
        set_idx(16'h0010);
        wait_rdy();
        rx_byte = 8'h02; push_stb = 1'b1;
        @(negedge clk);
        push_stb = 1'b0;
        chk("R8 start high", {start_pulse, stop_pulse}, 2'b10);
        @(negedge clk);
        chk("R8 start one cycle", start_pulse, 0);

        // R8 stop pulse through local write, R6 stretch
        lb_sel = 1'b1; lb_write = 1'b1; lb_addr = 10'h010; lb_wdata = 8'h01;
        @(negedge clk);
        chk("R9 write ready", lb_rdy, 1);
        chk("R8 stop high", {start_pulse, stop_pulse}, 2'b01);
        chk("R6 stretch during local", slv_rdy, 0);
        lb_sel = 1'b0; lb_write = 1'b0;
        @(negedge clk);
        chk("R8 stop one cycle", stop_pulse, 0);
        chk("R6 ready released", slv_rdy, 1);

        // R8 other value: no pulse
        lb_sel = 1'b1; lb_write = 1'b1; lb_addr = 10'h010; lb_wdata = 8'h03;
        @(negedge clk);
        chk("R8 no pulse for 0x03", {start_pulse, stop_pulse}, 2'b00);
        lb_sel = 1'b0; lb_write = 1'b0;
        @(negedge clk);

        // R6 / R9 read: ready low through the wait cycles
        lb_sel = 1'b1; lb_write = 1'b0; lb_addr = 10'h033;
        @(negedge clk);
        chk("R6 stretch in wait1", slv_rdy, 0);
        chk("R9 wait1", lb_rdy, 0);
        @(negedge clk);
        chk("R9 wait2", lb_rdy, 0);
        @(negedge clk);
        chk("R9 data ready", {lb_rdy, lb_rdata}, {1'b1, 8'hEF});
        lb_sel = 1'b0;
        @(negedge clk);
        chk("R9 ready single", lb_rdy, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule